// File: doc/BRIEF.md
# Dual-Modulus Swallow-Counter Feedback Divider

This block divides an input clock by a programmable ratio N = P·B + A. A modelled two-modulus prescaler counts input ticks. It divides by P+1 while the swallow count is nonzero and by P otherwise. A main counter of B prescaler periods sets the length of the full divide cycle. The first A prescaler periods of each cycle use the longer modulus, so the cycle lasts exactly P·B + A ticks.

When the half-rate select is set, only every second input clock counts as a tick. The output period then doubles without changing N. A setup that would need twice the ratio can therefore keep the smaller one.

A, B, P and the half-rate select are plain control inputs. They may change at any time, but the block samples them only at the boundary between divide cycles. Out-of-range values are clamped to the nearest legal value and flagged. There is no data stream, so the block has no handshake.

Top module: `dual_mod_divider`

## Requirements
- R1: With half-rate select low and legal settings (B ≥ 3, 2 ≤ P, A ≤ B), successive rising edges of `div_out` lie exactly P·B + A clock cycles apart.
- R2: With half-rate select high, only every second clock counts as a tick, so `div_out` pulses lie 2·(P·B + A) clock cycles apart.
- R3: Within one divide cycle, `mod_hi` is high for exactly A·(P+1) ticks, counted from the start of the cycle (doubled in clock cycles when half-rate is selected).
- R4: A B value below 3 raises `cfg_err` and is treated as 3.
- R5: An A value greater than B raises `cfg_err` and is treated as the (already clamped) B value.
- R6: A P value below 2 raises `cfg_err` and is treated as 2.
- R7: `cfg_err` is low whenever B ≥ 3, P ≥ 2 and A ≤ B. It follows the inputs combinationally.
- R8: New A, B, P and half-rate values take effect only at the start of the divide cycle that follows the next `div_out` pulse. A cycle already running keeps its old settings.
- R9: `div_out` is high for exactly one clock cycle per divide cycle.
- R10: While `rst` is high, `div_out` is low and the counters load the current settings, so `mod_hi` is high right after reset exactly when the effective A is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input (oscillator-side) clock |
| rst | input | 1 | Synchronous reset, active high |
| a_val | input | A_W | Swallow count A |
| b_val | input | B_W | Main count B |
| p_val | input | P_W | Prescaler base modulus P |
| half_sel | input | 1 | 1 = count every second clock only |
| mod_hi | output | 1 | Modulus control: 1 selects P+1, 0 selects P |
| div_out | output | 1 | One-cycle pulse at the end of every divide cycle |
| cfg_err | output | 1 | Requested settings are out of range and are being clamped |

## Verification
The bench builds the block with A_W = 3, B_W = 4 and P_W = 3, which makes the complete space of 1024 settings small enough to sweep. The sweep reaches every clamp case: B of 0 to 2, A above B, and P of 0 or 1. It also reaches the legal edge cases A = 0, A = B and the largest ratio. Settings change one clock after each pulse, so every check also tests that a new setting waits one full cycle before it applies. The half-rate select toggles across the sweep, so the tick alignment is checked at each switch between full and half rate.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
  // smallest main count the swallow scheme tolerates
  localparam int unsigned B_FLOOR = 3;
  // smallest base modulus the modelled prescaler supports
  localparam int unsigned P_FLOOR = 2;
endpackage

// File: rtl/dmd_cfg_guard.sv
module dmd_cfg_guard import dmd_pkg::*; #(
  parameter int unsigned A_W = 5,
  parameter int unsigned B_W = 13,
  parameter int unsigned P_W = 5
) (
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  logic [P_W-1:0] p_in,
  output logic [A_W-1:0] a_eff,
  output logic [B_W-1:0] b_eff,
  output logic [P_W-1:0] p_eff,
  output logic           err
);
  localparam int unsigned CW = (A_W > B_W) ? A_W : B_W;

  logic          b_low, p_low, a_over_raw;
  logic [CW-1:0] a_x, b_x;

  always_comb begin
    b_low      = b_in < B_W'(B_FLOOR);
    p_low      = p_in < P_W'(P_FLOOR);
    b_eff      = b_low ? B_W'(B_FLOOR) : b_in;
    p_eff      = p_low ? P_W'(P_FLOOR) : p_in;
    a_x        = CW'(a_in);
    b_x        = CW'(b_eff);
    a_over_raw = CW'(a_in) > CW'(b_in);
    // clamped B is below A here, so it fits in A_W bits
    a_eff      = (a_x > b_x) ? A_W'(b_x) : a_in;
    err        = b_low | p_low | a_over_raw;
  end
endmodule

// File: rtl/dmd_prescaler.sv
module dmd_prescaler #(
  parameter int unsigned P_W = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           mod_hi,
  input  logic [P_W-1:0] p_mod,
  output logic           pre_tc
);
  logic [P_W-1:0] pc;
  logic [P_W-1:0] last_idx;

  always_comb begin
    last_idx = mod_hi ? p_mod : (p_mod - P_W'(1));
    pre_tc   = (pc == last_idx);
  end

  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (tick) pc <= pre_tc ? '0 : pc + P_W'(1);
  end
endmodule

// File: rtl/dmd_swallow.sv
module dmd_swallow #(
  parameter int unsigned A_W = 5,
  parameter int unsigned B_W = 13
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           pre_tc,
  input  logic [A_W-1:0] a_load,
  input  logic [B_W-1:0] b_load,
  output logic [A_W-1:0] a_rem,
  output logic [B_W-1:0] b_rem,
  output logic           mod_hi,
  output logic           b_last
);
  always_comb begin
    mod_hi = (a_rem != '0);
    b_last = (b_rem == B_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rem <= a_load;
      b_rem <= b_load;
    end else if (tick && pre_tc) begin
      if (b_last) begin
        a_rem <= a_load;
        b_rem <= b_load;
      end else begin
        b_rem <= b_rem - B_W'(1);
        if (mod_hi) a_rem <= a_rem - A_W'(1);
      end
    end
  end
endmodule

// File: rtl/dual_mod_divider.sv
module dual_mod_divider #(
  parameter int unsigned A_W = 5,
  parameter int unsigned B_W = 13,
  parameter int unsigned P_W = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [A_W-1:0] a_val,
  input  logic [B_W-1:0] b_val,
  input  logic [P_W-1:0] p_val,
  input  logic           half_sel,
  output logic           mod_hi,
  output logic           div_out,
  output logic           cfg_err
);
  logic [A_W-1:0] a_eff;
  logic [B_W-1:0] b_eff;
  logic [P_W-1:0] p_eff;
  logic [P_W-1:0] cur_p;
  logic           cur_half;
  logic           half_ph;
  logic           tick;
  logic           pre_tc;
  logic           b_last;
  logic           cycle_end;
  logic [A_W-1:0] a_rem;
  logic [B_W-1:0] b_rem;

  dmd_cfg_guard #(.A_W(A_W), .B_W(B_W), .P_W(P_W)) u_guard (
    .a_in(a_val), .b_in(b_val), .p_in(p_val),
    .a_eff(a_eff), .b_eff(b_eff), .p_eff(p_eff), .err(cfg_err)
  );

  dmd_prescaler #(.P_W(P_W)) u_pre (
    .clk(clk), .rst(rst), .tick(tick), .mod_hi(mod_hi),
    .p_mod(cur_p), .pre_tc(pre_tc)
  );

  dmd_swallow #(.A_W(A_W), .B_W(B_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .pre_tc(pre_tc),
    .a_load(a_eff), .b_load(b_eff),
    .a_rem(a_rem), .b_rem(b_rem), .mod_hi(mod_hi), .b_last(b_last)
  );

  always_comb begin
    tick      = ~cur_half | half_ph;
    cycle_end = tick & pre_tc & b_last;
  end

  // settings that shape the running cycle are captured only at its boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_p    <= p_eff;
      cur_half <= half_sel;
      half_ph  <= 1'b0;
      div_out  <= 1'b0;
    end else begin
      half_ph <= cycle_end ? 1'b0 : ~half_ph;
      div_out <= cycle_end;
      if (cycle_end) begin
        cur_p    <= p_eff;
        cur_half <= half_sel;
      end
    end
  end
endmodule

// File: rtl/dmd_checker.sv
module dmd_checker #(
  parameter int unsigned A_W = 5,
  parameter int unsigned B_W = 13,
  parameter int unsigned P_W = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           div_out,
  input logic           mod_hi,
  input logic [P_W-1:0] cur_p,
  input logic [A_W-1:0] a_rem,
  input logic [B_W-1:0] b_rem
);
  localparam int unsigned CW = (A_W > B_W) ? A_W : B_W;

  assert_one_cycle_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    div_out |=> !div_out);

  assert_mod_rises_at_boundary_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_hi) |-> div_out);

  assert_modulus_held_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_p) |-> div_out);

  assert_swallow_within_main_R5: assert property (@(posedge clk) disable iff (rst)
    CW'(a_rem) <= CW'(b_rem));

  assert_main_floor_R4: assert property (@(posedge clk) disable iff (rst)
    div_out |-> (b_rem >= B_W'(3)));

  assert_modulus_floor_R6: assert property (@(posedge clk) disable iff (rst)
    cur_p >= P_W'(2));
endmodule

bind dual_mod_divider dmd_checker #(.A_W(A_W), .B_W(B_W), .P_W(P_W)) u_chk (
  .clk(clk), .rst(rst), .div_out(div_out), .mod_hi(mod_hi),
  .cur_p(cur_p), .a_rem(a_rem), .b_rem(b_rem)
);

// File: tb/test_dual_mod_divider.sv
module test_dual_mod_divider;
  localparam int unsigned A_W = 3;
  localparam int unsigned B_W = 4;
  localparam int unsigned P_W = 3;
  localparam int NCFG = 1 << (A_W + B_W + P_W);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [A_W-1:0] a_val = '0;
  logic [B_W-1:0] b_val = '0;
  logic [P_W-1:0] p_val = '0;
  logic half_sel = 1'b0;
  logic mod_hi, div_out, cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_mod_divider #(.A_W(A_W), .B_W(B_W), .P_W(P_W)) i_dual_mod_divider (
    .clk(clk), .rst(rst), .a_val(a_val), .b_val(b_val), .p_val(p_val),
    .half_sel(half_sel), .mod_hi(mod_hi), .div_out(div_out), .cfg_err(cfg_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected interval, mod-high cycles, error flag and tag for one setting index
  task automatic expect_for(input int idx, output int len, output int mc,
                            output int err, output string tag);
    int p = idx % 8;
    int a = (idx / 8) % 8;
    int b = (idx / 64) % 16;
    int h = (idx % 3 == 0) ? 1 : 0;
    int pe = (p < 2) ? 2 : p;
    int be = (b < 3) ? 3 : b;
    int ae = (a > be) ? be : a;
    len = (pe * be + ae) * (h + 1);
    mc  = ae * (pe + 1) * (h + 1);
    err = (b < 3 || p < 2 || a > b) ? 1 : 0;
    if (b < 3)      tag = "R4/R8";
    else if (a > b) tag = "R5/R8";
    else if (p < 2) tag = "R6/R8";
    else if (h)     tag = "R2/R8";
    else            tag = "R1/R8";
  endtask

  task automatic apply(input int idx);
    p_val    = P_W'(idx % 8);
    a_val    = A_W'((idx / 8) % 8);
    b_val    = B_W'((idx / 64) % 16);
    half_sel = (idx % 3 == 0);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 190000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cur_len, cur_mc, pend_len, pend_mc, e_err, cyc, mcnt, next_idx, pulses;
    string cur_tag, pend_tag;
    bit first;
    int raw_a;
    // setting index with A=5, B=2 (clamps to B=3, A=3), P=4, full rate
    apply(172);
    expect_for(172, cur_len, cur_mc, e_err, cur_tag);
    repeat (3) begin
      @(negedge clk);
      check("R10 div_out low in reset", int'(div_out), 0);
    end
    @(negedge clk); rst = 1'b0;
    check("R10 mod_hi after reset", int'(mod_hi), 1);
    check("R4 cfg_err for B=2", int'(cfg_err), 1);
    pend_len = cur_len; pend_mc = cur_mc; pend_tag = cur_tag;
    first = 1; cyc = 0; mcnt = 0; next_idx = 0; pulses = 0;
    while (pulses < NCFG + 2) begin
      @(negedge clk);
      if (div_out) begin
        if (!first) begin
          check({cur_tag, " interval"}, cyc, cur_len);
          check("R3 mod_hi cycles", mcnt, cur_mc);
        end
        first = 0; cyc = 0; mcnt = 0; pulses++;
        // settings latched at this pulse govern the interval now starting
        cur_len = pend_len; cur_mc = pend_mc; cur_tag = pend_tag;
        if (next_idx < NCFG) begin
          apply(next_idx);
          expect_for(next_idx, pend_len, pend_mc, e_err, pend_tag);
          #1;
          raw_a = next_idx;
          check(e_err ? "R4/R5/R6 cfg_err raised" : "R7 cfg_err clear",
                int'(cfg_err), e_err);
          next_idx++;
        end
      end else if (cyc == 1) begin
        check("R9 pulse single cycle", int'(div_out), 0);
      end
      cyc++;
      if (mod_hi) mcnt++;
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule